// File: doc/BRIEF.md
# Display Blink Timing Controller

This block drives a single display-enable line that switches a multiplexed LED display between lit and dark at one of two blink rates. A free-running prescaler counts system clocks into half-second steps, and a small phase engine turns those steps into lit and dark phases. When blinking is switched off the display simply stays lit. The four configuration inputs come from a feature register held elsewhere: blink enable, slow rate, sync-on-load and start-lit.

Several of these controllers can sit in a daisy chain that shares one load strobe. When sync-on-load is set, every rising edge of the load strobe clears the timing counter and restarts the blink cycle, so all devices in the chain blink in step. A one-cycle pulse on `timing_clr_o` reports each such clear, so the digit multiplexer can restart its own scan counter. The load strobe is asynchronous to the system clock. It passes through a synchroniser chain before its rising edge is detected.

The number of system clocks per half second is a parameter. At a 50 MHz clock it defaults to 25,000,000, and a simulation can set a small value.

Top module: `blink_ctrl_top`

## Requirements
- R1: While `cfg_blink_en` is 0, `disp_on_o` is 1 on every cycle after the first edge at which it was seen low.
- R2: With `cfg_slow_rate` = 0 (fast rate), each lit or dark phase lasts HALF_CLKS clocks, giving a period of 2*HALF_CLKS clocks.
- R3: With `cfg_slow_rate` = 1 (slow rate), each lit or dark phase lasts 2*HALF_CLKS clocks, giving a period of 4*HALF_CLKS clocks.
- R4: A 0-to-1 change of `cfg_blink_en` restarts the cycle. From the next clock edge, `disp_on_o` equals `cfg_start_lit` (1 = start lit, 0 = start dark), and the first phase is a full phase.
- R5: With `cfg_sync_on_load` = 1, a rising edge on `load_i` restarts the prescaler and the phase. From the third clock edge after the input change, `disp_on_o` equals `cfg_start_lit`, a full phase begins, and `timing_clr_o` is 1 for exactly that one cycle.
- R6: With `cfg_sync_on_load` = 0, edges on `load_i` have no effect on `disp_on_o`, and `timing_clr_o` stays 0.
- R7: A change of `cfg_slow_rate` during a phase does not alter the length of that phase. The new rate governs phases from the next phase boundary onward.
- R8: Synchronous reset (`rst` = 1) drives `disp_on_o` to 1 and `timing_clr_o` to 0 at the next edge, whatever state the block was in.
- R9: `timing_clr_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_blink_en | input | 1 | Blink enable; 0 keeps the display lit |
| cfg_slow_rate | input | 1 | 0: phases of one half second; 1: phases of one second |
| cfg_sync_on_load | input | 1 | 1: a rising edge of `load_i` clears the timing |
| cfg_start_lit | input | 1 | Phase after a restart: 1 lit, 0 dark |
| load_i | input | 1 | Asynchronous load / chip-select strobe, idle high |
| disp_on_o | output | 1 | Registered display enable |
| timing_clr_o | output | 1 | One-cycle pulse when a load edge cleared the timing |

## Verification
The hardest case is a load-edge restart that can be told apart from the free-running cycle. The restart has to land where the unsynchronised cycle would already have flipped the display. The bench therefore lets a lit phase run partway, raises the load strobe, and checks that the display is still lit past the point where it would have gone dark. The rate-change case is handled the same way. The bench switches the rate one cycle into a fast phase and checks that this phase still ends on time and that the next one runs at the slow length.

// File: rtl/blink_pkg.sv
package blink_pkg;

  typedef enum logic {
    PH_DARK = 1'b0,
    PH_LIT  = 1'b1
  } phase_t;

  typedef struct packed {
    logic en;
    logic slow;
    logic sync;
    logic start;
  } blink_cfg_t;

endpackage

// File: rtl/blink_load_sync.sv
module blink_load_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b1;
        else     chain_q <= load_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], load_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[SYNC_STAGES-1];
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
  parameter int HALF_CLKS = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  output logic tick_o
);

  localparam int CNT_W = (HALF_CLKS > 2) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i)      cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/blink_phase.sv
module blink_phase
  import blink_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic tick_i,
  input  logic en_i,
  input  logic slow_i,
  input  logic start_i,
  output logic disp_o
);

  phase_t ph_q, ph_d;
  logic   half_q, half_d;
  logic   rate_q, rate_d;
  logic   disp_q;

  always_comb begin
    ph_d   = ph_q;
    half_d = half_q;
    rate_d = rate_q;
    if (restart_i) begin
      ph_d   = phase_t'(start_i);
      half_d = 1'b0;
      rate_d = slow_i;
    end else if (tick_i) begin
      if (rate_q && !half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        ph_d   = (ph_q == PH_LIT) ? PH_DARK : PH_LIT;
        rate_d = slow_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_DARK;
      half_q <= 1'b0;
      rate_q <= 1'b0;
      disp_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      half_q <= half_d;
      rate_q <= rate_d;
      disp_q <= en_i ? (ph_d == PH_LIT) : 1'b1;
    end
  end

  assign disp_o = disp_q;

endmodule

// File: rtl/blink_ctrl_top.sv
module blink_ctrl_top
  import blink_pkg::*;
#(
  parameter int HALF_CLKS   = 25_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_blink_en,
  input  logic cfg_slow_rate,
  input  logic cfg_sync_on_load,
  input  logic cfg_start_lit,
  input  logic load_i,
  output logic disp_on_o,
  output logic timing_clr_o
);

  blink_cfg_t cfg;
  logic       en_q;
  logic       load_rise;
  logic       sync_clr;
  logic       restart;
  logic       half_tick;
  logic       clr_q;

  assign cfg = '{en: cfg_blink_en, slow: cfg_slow_rate,
                 sync: cfg_sync_on_load, start: cfg_start_lit};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      en_q  <= cfg.en;
      clr_q <= sync_clr;
    end
  end

  assign sync_clr = load_rise & cfg.sync;
  assign restart  = sync_clr | (cfg.en & ~en_q);

  blink_load_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .rise_o (load_rise)
  );

  blink_prescaler #(.HALF_CLKS(HALF_CLKS)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .clear_i (restart),
    .tick_o  (half_tick)
  );

  blink_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .tick_i    (half_tick),
    .en_i      (cfg.en),
    .slow_i    (cfg.slow),
    .start_i   (cfg.start),
    .disp_o    (disp_on_o)
  );

  assign timing_clr_o = clr_q;

endmodule

// File: rtl/blink_ctrl_chk.sv
module blink_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cfg_blink_en,
  input logic cfg_sync_on_load,
  input logic cfg_start_lit,
  input logic disp_on_o,
  input logic timing_clr_o
);

  // R1
  blink_off_lit_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_blink_en |=> disp_on_o);

  // R4
  start_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_blink_en) |=> (disp_on_o == $past(cfg_start_lit)));

  // R5
  sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (timing_clr_o && $past(cfg_blink_en)) |-> (disp_on_o == $past(cfg_start_lit)));

  // R6
  no_sync_no_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_sync_on_load |=> !timing_clr_o);

  // R9
  clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    timing_clr_o |=> !timing_clr_o);

endmodule

bind blink_ctrl_top blink_ctrl_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .cfg_blink_en     (cfg_blink_en),
  .cfg_sync_on_load (cfg_sync_on_load),
  .cfg_start_lit    (cfg_start_lit),
  .disp_on_o        (disp_on_o),
  .timing_clr_o     (timing_clr_o)
);

// File: tb/blink_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module blink_ctrl_top_tb_top;

  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, slow = 1'b0, syn = 1'b0, start = 1'b0, load = 1'b1;
  logic disp, clr;
  int   total = 0;
  int   bad = 0;

  always #10 clk = ~clk;

  blink_ctrl_top #(.HALF_CLKS(H), .SYNC_STAGES(2)) dut_i (
    .clk (clk), .rst (rst),
    .cfg_blink_en (en), .cfg_slow_rate (slow),
    .cfg_sync_on_load (syn), .cfg_start_lit (start),
    .load_i (load), .disp_on_o (disp), .timing_clr_o (clr)
  );

  // {slow, start, offset[4:0], expected disp}; offset counted in edges after enable edge
  localparam logic [7:0] VEC [16] = '{
    {1'b0, 1'b1, 5'd0,  1'b1}, {1'b0, 1'b1, 5'd3,  1'b1},
    {1'b0, 1'b1, 5'd4,  1'b0}, {1'b0, 1'b1, 5'd8,  1'b1},
    {1'b0, 1'b0, 5'd0,  1'b0}, {1'b0, 1'b0, 5'd4,  1'b1},
    {1'b0, 1'b0, 5'd7,  1'b1}, {1'b0, 1'b0, 5'd8,  1'b0},
    {1'b1, 1'b1, 5'd4,  1'b1}, {1'b1, 1'b1, 5'd7,  1'b1},
    {1'b1, 1'b1, 5'd8,  1'b0}, {1'b1, 1'b1, 5'd16, 1'b1},
    {1'b1, 1'b0, 5'd0,  1'b0}, {1'b1, 1'b0, 5'd8,  1'b1},
    {1'b1, 1'b0, 5'd15, 1'b1}, {1'b1, 1'b0, 5'd16, 1'b0}
  };

  task automatic check(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drop enable, set config, raise enable; returns at the negedge after the enable edge (j=0)
  task automatic restart_blink(input logic s, input logic st, input logic sy);
    en = 1'b0;
    edges(2);
    slow = s; start = st; syn = sy;
    en = 1'b1;
    edges(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    edges(3);
    // R8 reset state
    check("R8 reset disp", disp, 1'b1);
    check("R8 reset clr", clr, 1'b0);
    rst = 1'b0;

    // R1 blinking off keeps display lit
    for (int i = 0; i < 12; i++) begin
      edges(1);
      check("R1 disabled lit", disp, 1'b1);
    end

    // R2 R3 R4 table walk
    for (int v = 0; v < 16; v++) begin
      restart_blink(VEC[v][7], VEC[v][6], 1'b0);
      edges(int'(VEC[v][5:1]));
      check(VEC[v][7] ? "R3 slow phase (R4 start)" : "R2 fast phase (R4 start)",
            disp, VEC[v][0]);
    end

    // R7 rate change mid-phase
    restart_blink(1'b0, 1'b1, 1'b0);
    edges(1);
    slow = 1'b1;
    edges(3);
    check("R7 current phase keeps length", disp, 1'b0);
    edges(7);
    check("R7 new rate dark held", disp, 1'b0);
    edges(1);
    check("R7 new rate boundary", disp, 1'b1);

    // R5 sync clear restarts cycle
    restart_blink(1'b0, 1'b1, 1'b1);
    edges(6);
    load = 1'b0;
    edges(2);
    load = 1'b1;
    edges(3);
    check("R5 clear pulse", clr, 1'b1);
    check("R5 start phase after clear", disp, 1'b1);
    edges(1);
    check("R9 clear pulse single", clr, 1'b0);
    check("R5 phase restarted", disp, 1'b1);
    edges(2);
    check("R5 restarted phase held", disp, 1'b1);
    edges(1);
    check("R5 restarted phase ends", disp, 1'b0);

    // R6 load edges ignored without sync
    restart_blink(1'b0, 1'b1, 1'b0);
    load = 1'b0;
    edges(2);
    load = 1'b1;
    edges(3);
    check("R6 no restart", disp, 1'b0);
    check("R6 no clear pulse", clr, 1'b0);

    // R8 reset in the middle of a dark phase
    rst = 1'b1;
    edges(1);
    check("R8 mid-run reset disp", disp, 1'b1);
    check("R8 mid-run reset clr", clr, 1'b0);
    rst = 1'b0;
    en = 1'b0;
    edges(2);

    finish_run();
  end

endmodule